// File: doc/BRIEF.md
# Half-Bridge Command Interlock

This block turns the high-side and low-side switch commands of a half-bridge into the two gate enables that the output stages act on. Each command is first brought into the clock domain by a two-flop synchronizer and then passed through a glitch filter. The filter lets a level through only after it has been stable for a set number of clock cycles. The filtered commands feed an interlock. The interlock never asserts both enables at once. When both commands are high it holds the enables it already had. The high-side enable is driven by edges of its command.

Two override inputs sit on top of the interlock. An active-low shutdown from the protection logic clears both enables. A high-side inhibit clears only the high-side enable and leaves the low side running. Once an override is released, an enable that it cleared stays low until its own command shows a fresh rising edge. A command that is merely held high across the release does not bring the enable back.

Top module: `hb_interlock`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, both `hi_gate` and `lo_gate` are 0.
- R2: A command pulse that lasts fewer than `FILT_CYC` clock cycles never reaches the gates. A pulse of exactly `FILT_CYC` cycles does reach them.
- R3: With no override active, a command change that is set up before a rising clock edge shows on the gate at the (`FILT_CYC`+3)-th rising edge, counting that edge as the first.
- R4: `hi_gate` and `lo_gate` are never 1 in the same cycle.
- R5: A rising high-side command while the low-side command is low drives `hi_gate` to 1 and `lo_gate` to 0.
- R6: While both filtered commands stay high, both gates keep their values.
- R7: When both commands rise in the same cycle, `hi_gate` becomes 1 and `lo_gate` stays 0.
- R8: When a both-high period ends with one command low and the other still high, only the gate of the still-high command is 1. This includes the case where the high-side command falls while the low-side command is high.
- R9: With only the low-side command high and that side armed, `lo_gate` is 1 and `hi_gate` is 0. With both commands low, both gates are 0.
- R10: While `hi_inhibit` is 1, `hi_gate` is 0 from the next cycle on, and `lo_gate` keeps following the low-side command.
- R11: While `shut_n` is 0, both gates are 0 from the next cycle on.
- R12: After `shut_n` returns to 1 or `hi_inhibit` returns to 0, a gate that the override cleared stays 0 until its own command rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the whole block |
| rst_n | input | 1 | Active-low reset, released synchronously |
| hi_cmd | input | 1 | High-side switch command, asynchronous |
| lo_cmd | input | 1 | Low-side switch command, asynchronous |
| shut_n | input | 1 | Active-low shutdown from the protection block, synchronous |
| hi_inhibit | input | 1 | Forces the high-side enable low, synchronous |
| hi_gate | output | 1 | Registered high-side gate enable |
| lo_gate | output | 1 | Registered low-side gate enable |

## Verification
The assertions assume that `shut_n` and `hi_inhibit` are already synchronous to `clk`. Only the two commands go through the synchronizer, so the overrides are taken to change exactly at clock edges. The bench therefore drives every input on the falling edge. It changes the two commands together whenever a requirement calls for simultaneous edges, so that both travel identical pipelines. Every step of the vector table is held much longer than the filter time. This keeps each step outside the filter window, except for the pulses that test the filter on purpose.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    // Registered state of the interlock core
    typedef struct packed {
        logic hg;       // high-side gate enable
        logic lg;       // low-side gate enable
        logic h_arm;    // high side has seen a fresh rise since last override
        logic l_arm;    // low side has seen a fresh rise since last shutdown
        logic h_prev;   // filtered high command, one cycle back
        logic l_prev;   // filtered low command, one cycle back
    } core_st_t;

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/hbi_filter.sv
module hbi_filter #(
    parameter int FILT_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic flt
);

    localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
    localparam logic [CW-1:0] CNT_TOP = CW'(FILT_CYC - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_TOP) begin
            st_d.lvl = raw;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flt = st_q.lvl;

endmodule

// File: rtl/hbi_core.sv
module hbi_core
    import hbi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic h,
    input  logic l,
    input  logic shut_n,
    input  logic inh,
    output logic hg,
    output logic lg
);

    core_st_t st_d, st_q;
    logic rise_h, rise_l, sd;

    always_comb begin
        st_d   = st_q;
        sd     = ~shut_n;
        rise_h = h & ~st_q.h_prev;
        rise_l = l & ~st_q.l_prev;

        st_d.h_prev = h;
        st_d.l_prev = l;

        // arming: an override clears it, a fresh rise restores it
        if (sd || inh)   st_d.h_arm = 1'b0;
        else if (rise_h) st_d.h_arm = 1'b1;

        if (sd)          st_d.l_arm = 1'b0;
        else if (rise_l) st_d.l_arm = 1'b1;

        unique case ({h, l})
            2'b11: begin
                if (rise_h && rise_l) begin
                    st_d.hg = st_d.h_arm;
                    st_d.lg = 1'b0;
                end else begin
                    st_d.hg = st_q.hg;
                    st_d.lg = st_q.lg;
                end
            end
            2'b10: begin
                st_d.hg = st_d.h_arm;
                st_d.lg = 1'b0;
            end
            2'b01: begin
                st_d.hg = 1'b0;
                st_d.lg = st_d.l_arm;
            end
            default: begin
                st_d.hg = 1'b0;
                st_d.lg = 1'b0;
            end
        endcase

        if (inh) st_d.hg = 1'b0;
        if (sd) begin
            st_d.hg = 1'b0;
            st_d.lg = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hg = st_q.hg;
    assign lg = st_q.lg;

endmodule

// File: rtl/hb_interlock.sv
module hb_interlock #(
    parameter int FILT_CYC    = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic shut_n,
    input  logic hi_inhibit,
    output logic hi_gate,
    output logic lo_gate
);

    localparam int NCH = 2;   // channel 1 = high side, channel 0 = low side

    logic [NCH-1:0] syn;
    logic [NCH-1:0] flt;
    logic h_syn, l_syn, h_flt, l_flt;

    hbi_sync #(
        .WIDTH  (NCH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({hi_cmd, lo_cmd}),
        .dout  (syn)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_filt
        hbi_filter #(
            .FILT_CYC (FILT_CYC)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (syn[c]),
            .flt   (flt[c])
        );
    end

    assign h_syn = syn[1];
    assign l_syn = syn[0];
    assign h_flt = flt[1];
    assign l_flt = flt[0];

    hbi_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .h      (h_flt),
        .l      (l_flt),
        .shut_n (shut_n),
        .inh    (hi_inhibit),
        .hg     (hi_gate),
        .lg     (lo_gate)
    );

endmodule

// File: rtl/hbi_checks.sv
module hbi_checks (
    input logic clk,
    input logic rst_n,
    input logic shut_n,
    input logic hi_inhibit,
    input logic hi_gate,
    input logic lo_gate,
    input logic h_syn,
    input logic l_syn,
    input logic h_flt,
    input logic l_flt
);

    // R4
    gates_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_gate && lo_gate));

    // R11
    shutdown_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shut_n |=> (!hi_gate && !lo_gate));

    // R10
    inhibit_clears_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_inhibit |=> !hi_gate);

    // R6
    both_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_flt && l_flt && $past(h_flt) && $past(l_flt) && shut_n && !hi_inhibit)
        |=> ($stable(hi_gate) && $stable(lo_gate)));

    // R5
    hi_rise_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_gate) |-> $past(h_flt));

    // R9
    lo_rise_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_gate) |-> ($past(l_flt) && !$past(h_flt)));

    // R2
    hi_filter_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(h_flt) |-> ($past(h_syn) == h_flt));

    // R2
    lo_filter_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(l_flt) |-> ($past(l_syn) == l_flt));

endmodule

bind hb_interlock hbi_checks u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shut_n     (shut_n),
    .hi_inhibit (hi_inhibit),
    .hi_gate    (hi_gate),
    .lo_gate    (lo_gate),
    .h_syn      (h_syn),
    .l_syn      (l_syn),
    .h_flt      (h_flt),
    .l_flt      (l_flt)
);

// File: tb/sim_hb_interlock.sv
module sim_hb_interlock;

    localparam int N      = 50;
    localparam int SETTLE = N + 12;
    localparam int NVEC   = 27;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_cmd = 1'b0, lo_cmd = 1'b0, shut_n = 1'b1, hi_inhibit = 1'b0;
    logic hi_gate, lo_gate;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    hb_interlock #(.FILT_CYC(N)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .hi_cmd     (hi_cmd),
        .lo_cmd     (lo_cmd),
        .shut_n     (shut_n),
        .hi_inhibit (hi_inhibit),
        .hi_gate    (hi_gate),
        .lo_gate    (lo_gate)
    );

    // {hi_cmd, lo_cmd, shut_n, hi_inhibit, exp_hi, exp_lo}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b00_10_00,  // 0  R9 both low
        6'b10_10_10,  // 1  R5 high rises alone
        6'b11_10_10,  // 2  R6 hold
        6'b01_10_01,  // 3  R8 high falls, low high
        6'b11_10_01,  // 4  R6 hold
        6'b10_10_10,  // 5  R8 low falls, high still high
        6'b00_10_00,  // 6  R9
        6'b11_10_10,  // 7  R7 simultaneous rise
        6'b00_10_00,  // 8  R9
        6'b01_10_01,  // 9  R9 low alone
        6'b11_10_01,  // 10 R6 hold
        6'b00_10_00,  // 11 R9
        6'b10_10_10,  // 12 R5
        6'b10_11_00,  // 13 R10 inhibit
        6'b10_10_00,  // 14 R12 waits after inhibit
        6'b00_10_00,  // 15 R9
        6'b10_10_10,  // 16 R12 fresh rise
        6'b01_11_01,  // 17 R10 low runs under inhibit
        6'b01_10_01,  // 18 R10
        6'b01_00_00,  // 19 R11 shutdown
        6'b01_10_00,  // 20 R12 waits after shutdown
        6'b00_10_00,  // 21 R9
        6'b01_10_01,  // 22 R12 fresh rise
        6'b10_00_00,  // 23 R11 rise during shutdown
        6'b10_10_00,  // 24 R12 rise consumed by shutdown
        6'b11_10_00,  // 25 R6 hold
        6'b01_10_01   // 26 R8
    };

    function automatic string req_of(int i);
        case (i)
            1, 12:              return "R5";
            2, 4, 10, 25:       return "R6";
            3, 5, 26:           return "R8";
            7:                  return "R7";
            13, 17, 18:         return "R10";
            19, 23:             return "R11";
            14, 16, 20, 22, 24: return "R12";
            default:            return "R9";
        endcase
    endfunction

    task automatic check2(string req, logic exp_h, logic exp_l);
        checks++;
        if (hi_gate !== exp_h || lo_gate !== exp_l) begin
            errors++;
            $display("FAIL %s: gates hi=%b lo=%b, expected hi=%b lo=%b",
                     req, hi_gate, lo_gate, exp_h, exp_l);
        end
    endtask

    task automatic wait_neg(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit seen;

        // R1 reset
        wait_neg(5);
        check2("R1", 1'b0, 1'b0);
        rst_n = 1'b1;
        wait_neg(1);
        check2("R1", 1'b0, 1'b0);
        wait_neg(SETTLE);

        // R3 latency: set before edge k, visible after edge k+N+2
        hi_cmd = 1'b1;
        for (int i = 0; i < N + 2; i++) @(posedge clk);
        @(negedge clk);
        check2("R3", 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check2("R3", 1'b1, 1'b0);
        hi_cmd = 1'b0;
        wait_neg(SETTLE);
        check2("R9", 1'b0, 1'b0);

        // R2 short pulse is dropped
        seen = 1'b0;
        hi_cmd = 1'b1;
        wait_neg(N - 1);
        hi_cmd = 1'b0;
        for (int i = 0; i < 3 * N; i++) begin
            @(negedge clk);
            if (hi_gate) seen = 1'b1;
        end
        checks++;
        if (seen) begin
            errors++;
            $display("FAIL R2: short pulse reached hi_gate=1, expected 0");
        end

        // R2 pulse of exactly N cycles passes
        seen = 1'b0;
        hi_cmd = 1'b1;
        wait_neg(N);
        hi_cmd = 1'b0;
        for (int i = 0; i < 3 * N; i++) begin
            @(negedge clk);
            if (hi_gate) seen = 1'b1;
        end
        checks++;
        if (!seen) begin
            errors++;
            $display("FAIL R2: full-length pulse gave hi_gate=0, expected 1");
        end

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            hi_cmd     = VEC[v][5];
            lo_cmd     = VEC[v][4];
            shut_n     = VEC[v][3];
            hi_inhibit = VEC[v][2];
            wait_neg(SETTLE);
            check2(req_of(v), VEC[v][1], VEC[v][0]);
        end

        // R11 shutdown acts in the next cycle
        hi_cmd = 1'b1; lo_cmd = 1'b0;
        wait_neg(SETTLE);
        check2("R5", 1'b1, 1'b0);
        shut_n = 1'b0;
        wait_neg(1);
        check2("R11", 1'b0, 1'b0);
        shut_n = 1'b1;

        // R1 reset clears a high gate
        hi_cmd = 1'b0;
        wait_neg(SETTLE);
        hi_cmd = 1'b1;
        wait_neg(SETTLE);
        check2("R5", 1'b1, 1'b0);
        rst_n = 1'b0;
        wait_neg(2);
        check2("R1", 1'b0, 1'b0);
        rst_n = 1'b1;
        hi_cmd = 1'b0;
        wait_neg(SETTLE);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule